// File: doc/BRIEF.md
# Word ALU with Extra-Result Register

This block is the arithmetic and logic stage of a 16-bit word machine. Each cycle it may accept one operation: an opcode, the destination operand value `b`, the source operand value `a`, and the present content of the machine's extra-result register. It returns the new destination value, the new extra-result value, a write strobe for each, a strobe that asks the register file to bump both index registers, and the number of machine cycles the operation is charged.

The extra-result register carries the side product of an operation. Depending on the operation, that is the carry, the borrow, the high product word, the fractional quotient word, or the bits shifted out. All results are registered, so the answer to an operation issued in one cycle is on the outputs in the next cycle. A new operation may be issued every cycle. Operand fetch, memory access and conditional execution stay with the surrounding pipeline.

When a result is not written, the output carries the input value through unchanged: `out_b` equals `in_b` and `out_ex` equals `in_ex`.

Top module: `word_alu`

## Requirements
- R1: The operation presented with `in_valid` high at a rising edge appears on the outputs right after that edge, with `out_valid` high. An edge with `in_valid` low leaves `out_valid` and all three strobes low. Reset clears `out_valid`, the strobes and `out_cost`.
- R2: Move (opcode 0) writes `a` into b. AND (8), OR (9) and XOR (10) write `b & a`, `b | a` and `b ^ a`. None of these writes EX, and `out_ex` equals `in_ex`. Each costs 1 cycle.
- R3: Add (1) writes the low 16 bits of `b + a` and sets EX to 0x0001 on unsigned carry out, else 0. Subtract (2) writes `b - a` mod 2^16 and sets EX to 0xFFFF when `a > b`, else 0. Both cost 2 cycles.
- R4: Unsigned multiply (3) and signed multiply (4) write the low word of the 32-bit product to b and the high word to EX. Both cost 2 cycles.
- R5: With a nonzero divisor, unsigned divide (5) writes `b / a` and EX = low 16 bits of `(b * 65536) / a`. Signed divide (6) does the same on two's-complement values, truncating toward zero. Both cost 3 cycles.
- R6: With `a == 0`, both divides write 0 to b and 0 to EX. The remainder operation writes 0 to b and leaves EX unwritten.
- R7: Remainder (7) writes the unsigned `b mod a`, does not write EX, and costs 3 cycles.
- R8: Left shift (11) by amount `a` writes the low word of `b * 2^a` and sets EX to the next 16 bits of that product. An amount of 16 or more writes 0 to b. Cost is 2 cycles.
- R9: Logical right shift (12) and arithmetic right shift (13) take `b` placed in the high half of a 32-bit word and shift it right by `a`. The high half goes to b and the low half to EX. Logical fills with zeros; arithmetic fills with copies of bit 15. For amounts of 16 or more, b becomes all zeros or all sign copies. Cost is 2 cycles.
- R10: Add-with-carry (14) writes the low word of `b + a + EX` and sets EX to 1 when that sum exceeds 0xFFFF, else 0. Subtract-with-borrow (15) writes `b - a - EX` mod 2^16 and sets EX to 1 when that difference is negative, else 0. Both cost 3 cycles.
- R11: Move-with-increment (16) writes `a` into b, raises `out_ij_inc`, leaves EX unwritten, and costs 2 cycles. No other opcode raises `out_ij_inc`.
- R12: Opcodes 17 to 31 write nothing, raise no strobe, report cost 0, and pass `in_b` and `in_ex` through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is presented this cycle |
| in_op | input | 5 | Opcode |
| in_b | input | 16 | Destination operand value |
| in_a | input | 16 | Source operand value |
| in_ex | input | 16 | Current extra-result register value |
| out_valid | output | 1 | Result of last cycle's operation is present |
| out_b | output | 16 | New destination value |
| out_b_we | output | 1 | Destination write strobe |
| out_ex | output | 16 | New extra-result value |
| out_ex_we | output | 1 | Extra-result write strobe |
| out_ij_inc | output | 1 | Increment both index registers |
| out_cost | output | 2 | Machine cycles charged for the operation |

## Verification
Every result of this block arrives exactly one clock edge after its operation is taken, and no path is slower. The bench therefore drives an operation on a falling edge and reads all outputs on the following falling edge. This places each read midway between the capturing edge and the next one. Vectors are issued back to back, so every capture also overwrites the one before it. The idle case is checked on the first falling edge after `in_valid` drops, and the reset state before the first operation is issued.

// File: rtl/word_alu_pkg.sv
package word_alu_pkg;

  typedef enum logic [4:0] {
    OP_MOVE   = 5'd0,
    OP_ADD    = 5'd1,
    OP_SUB    = 5'd2,
    OP_MULU   = 5'd3,
    OP_MULS   = 5'd4,
    OP_DIVU   = 5'd5,
    OP_DIVS   = 5'd6,
    OP_REM    = 5'd7,
    OP_AND    = 5'd8,
    OP_OR     = 5'd9,
    OP_XOR    = 5'd10,
    OP_SHL    = 5'd11,
    OP_SHRL   = 5'd12,
    OP_SHRA   = 5'd13,
    OP_ADDC   = 5'd14,
    OP_SUBB   = 5'd15,
    OP_MOVINC = 5'd16
  } op_e;

  localparam int COST_W = 2;

endpackage

// File: rtl/wa_addsub.sv
module wa_addsub
  import word_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  op_e          op,
  input  logic [W-1:0] b,
  input  logic [W-1:0] a,
  input  logic [W-1:0] ex,
  output logic [W-1:0] res,
  output logic [W-1:0] ex_new,
  output logic         flag
);
  localparam int XW = W + 2;

  function automatic logic [XW-1:0] widen(input logic [W-1:0] v);
    return {2'b00, v};
  endfunction

  logic [XW-1:0] sum, dif;

  always_comb begin
    sum = widen(b) + widen(a) + ((op == OP_ADDC) ? widen(ex) : '0);
    dif = widen(b) - widen(a) - ((op == OP_SUBB) ? widen(ex) : '0);
    res = sum[W-1:0];
    flag = 1'b0;
    ex_new = '0;
    unique case (op)
      OP_ADD: begin
        flag = sum[W];
        ex_new = {{(W-1){1'b0}}, flag};
      end
      OP_ADDC: begin
        flag = |sum[XW-1:W];
        ex_new = {{(W-1){1'b0}}, flag};
      end
      OP_SUB: begin
        res = dif[W-1:0];
        flag = dif[XW-1];
        ex_new = {W{flag}};
      end
      OP_SUBB: begin
        res = dif[W-1:0];
        flag = dif[XW-1];
        ex_new = {{(W-1){1'b0}}, flag};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/wa_muldiv.sv
module wa_muldiv
  import word_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  op_e          op,
  input  logic [W-1:0] b,
  input  logic [W-1:0] a,
  output logic [W-1:0] res,
  output logic [W-1:0] ex_new,
  output logic         zero_div
);
  localparam int PW = 2 * W;
  localparam int DW = 3 * W;

  function automatic logic signed [DW-1:0] sext3(input logic [W-1:0] v);
    return $signed({{(DW-W){v[W-1]}}, v});
  endfunction

  logic [W-1:0]           dvs;
  logic [PW-1:0]          uprod, sprod, ufrac;
  logic signed [DW-1:0]   sq, sfrac;

  assign zero_div = (a == '0);
  assign dvs      = zero_div ? {{(W-1){1'b0}}, 1'b1} : a;

  always_comb begin
    uprod = {{W{1'b0}}, b} * {{W{1'b0}}, a};
    sprod = PW'($signed(b) * $signed(a));
    ufrac = {b, {W{1'b0}}} / {{W{1'b0}}, dvs};
    sq    = sext3(b) / sext3(dvs);
    sfrac = (sext3(b) <<< W) / sext3(dvs);
    res = '0;
    ex_new = '0;
    unique case (op)
      OP_MULU: begin res = uprod[W-1:0]; ex_new = uprod[PW-1:W]; end
      OP_MULS: begin res = sprod[W-1:0]; ex_new = sprod[PW-1:W]; end
      OP_DIVU: if (!zero_div) begin res = b / dvs; ex_new = ufrac[W-1:0]; end
      OP_DIVS: if (!zero_div) begin res = sq[W-1:0]; ex_new = sfrac[W-1:0]; end
      OP_REM:  if (!zero_div) res = b % dvs;
      default: ;
    endcase
  end
endmodule

// File: rtl/wa_shift.sv
module wa_shift
  import word_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  op_e          op,
  input  logic [W-1:0] b,
  input  logic [W-1:0] amt,
  output logic [W-1:0] res,
  output logic [W-1:0] ex_new,
  output logic         big
);
  localparam int PW = 2 * W;

  logic [PW-1:0] wide;

  assign big = (amt >= W[W-1:0]);

  always_comb begin
    wide = '0;
    res = '0;
    ex_new = '0;
    unique case (op)
      OP_SHL: begin
        wide = {{W{1'b0}}, b} << amt;
        res = wide[W-1:0];
        ex_new = wide[PW-1:W];
      end
      OP_SHRL: begin
        wide = {b, {W{1'b0}}} >> amt;
        res = wide[PW-1:W];
        ex_new = wide[W-1:0];
      end
      OP_SHRA: begin
        wide = $signed({b, {W{1'b0}}}) >>> amt;
        res = wide[PW-1:W];
        ex_new = wide[W-1:0];
      end
      default: ;
    endcase
  end

  always_comb begin
    if (big && op == OP_SHL)
      assert_shl_flush_R8: assert (res == '0);
    if (big && op == OP_SHRA)
      assert_sra_fill_R9: assert (res == {W{b[W-1]}});
  end
endmodule

// File: rtl/word_alu.sv
module word_alu
  import word_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [4:0]        in_op,
  input  logic [W-1:0]      in_b,
  input  logic [W-1:0]      in_a,
  input  logic [W-1:0]      in_ex,
  output logic              out_valid,
  output logic [W-1:0]      out_b,
  output logic              out_b_we,
  output logic [W-1:0]      out_ex,
  output logic              out_ex_we,
  output logic              out_ij_inc,
  output logic [COST_W-1:0] out_cost
);
  op_e op;
  assign op = op_e'(in_op);

  logic [W-1:0] as_res, as_ex, md_res, md_ex, sh_res, sh_ex;
  logic         carry_hit, div_zero, shift_big;

  wa_addsub #(.W(W)) u_addsub (.op(op), .b(in_b), .a(in_a), .ex(in_ex),
                               .res(as_res), .ex_new(as_ex), .flag(carry_hit));
  wa_muldiv #(.W(W)) u_muldiv (.op(op), .b(in_b), .a(in_a),
                               .res(md_res), .ex_new(md_ex), .zero_div(div_zero));
  wa_shift  #(.W(W)) u_shift  (.op(op), .b(in_b), .amt(in_a),
                               .res(sh_res), .ex_new(sh_ex), .big(shift_big));

  logic [W-1:0]      nx_b, nx_ex_val;
  logic              nx_bwe, nx_exwe, nx_ij;
  logic [COST_W-1:0] nx_cost;

  always_comb begin
    nx_b = in_b;
    nx_ex_val = in_ex;
    nx_bwe = 1'b1;
    nx_exwe = 1'b0;
    nx_ij = 1'b0;
    nx_cost = 2'd1;
    unique case (op)
      OP_MOVE: nx_b = in_a;
      OP_AND:  nx_b = in_b & in_a;
      OP_OR:   nx_b = in_b | in_a;
      OP_XOR:  nx_b = in_b ^ in_a;
      OP_ADD, OP_SUB: begin
        nx_b = as_res; nx_ex_val = as_ex; nx_exwe = 1'b1; nx_cost = 2'd2;
      end
      OP_ADDC, OP_SUBB: begin
        nx_b = as_res; nx_ex_val = as_ex; nx_exwe = 1'b1; nx_cost = 2'd3;
      end
      OP_MULU, OP_MULS: begin
        nx_b = md_res; nx_ex_val = md_ex; nx_exwe = 1'b1; nx_cost = 2'd2;
      end
      OP_DIVU, OP_DIVS: begin
        nx_b = md_res; nx_ex_val = md_ex; nx_exwe = 1'b1; nx_cost = 2'd3;
      end
      OP_REM: begin
        nx_b = md_res; nx_cost = 2'd3;
      end
      OP_SHL, OP_SHRL, OP_SHRA: begin
        nx_b = sh_res; nx_ex_val = sh_ex; nx_exwe = 1'b1; nx_cost = 2'd2;
      end
      OP_MOVINC: begin
        nx_b = in_a; nx_ij = 1'b1; nx_cost = 2'd2;
      end
      default: begin
        nx_bwe = 1'b0; nx_cost = 2'd0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_b      <= '0;
      out_ex     <= '0;
      out_b_we   <= 1'b0;
      out_ex_we  <= 1'b0;
      out_ij_inc <= 1'b0;
      out_cost   <= '0;
    end else begin
      out_valid  <= in_valid;
      out_b_we   <= in_valid & nx_bwe;
      out_ex_we  <= in_valid & nx_exwe;
      out_ij_inc <= in_valid & nx_ij;
      if (in_valid) begin
        out_b    <= nx_b;
        out_ex   <= nx_ex_val;
        out_cost <= nx_cost;
      end
    end
  end

  assert_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !out_b_we && !out_ex_we && !out_ij_inc);
  assert_logic_keeps_ex_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (op == OP_AND || op == OP_OR || op == OP_XOR || op == OP_MOVE)
    |=> !out_ex_we && out_ex == $past(in_ex) && out_cost == 2'd1);
  assert_add_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == OP_ADD |=> out_ex_we && out_ex[W-1:1] == '0);
  assert_div_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && div_zero && (op == OP_DIVU || op == OP_DIVS)
    |=> out_b == '0 && out_ex == '0);
  assert_ij_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op != OP_MOVINC |=> !out_ij_inc);
  assert_undef_R12: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_op > 5'd16 |=> !out_b_we && !out_ex_we && out_cost == 2'd0);
endmodule

// File: tb/tb_word_alu.sv
module tb_word_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [4:0]  in_op = '0;
  logic [15:0] in_b = '0, in_a = '0, in_ex = '0;
  logic        out_valid, out_b_we, out_ex_we, out_ij_inc;
  logic [15:0] out_b, out_ex;
  logic [1:0]  out_cost;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  word_alu dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
                .in_b(in_b), .in_a(in_a), .in_ex(in_ex), .out_valid(out_valid),
                .out_b(out_b), .out_b_we(out_b_we), .out_ex(out_ex),
                .out_ex_we(out_ex_we), .out_ij_inc(out_ij_inc), .out_cost(out_cost));

  typedef struct packed {
    logic [4:0]  op;
    logic [15:0] b, a, ex, eb, eex;
    logic        bwe, exwe, ij;
    logic [1:0]  cost;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VECS [NV] = '{
    '{5'd0,  16'h1234, 16'hABCD, 16'h5555, 16'hABCD, 16'h5555, 1'b1, 1'b0, 1'b0, 2'd1, 8'd2},  // R2 move
    '{5'd1,  16'hFFFF, 16'h0001, 16'h0000, 16'h0000, 16'h0001, 1'b1, 1'b1, 1'b0, 2'd2, 8'd3},  // R3 carry
    '{5'd1,  16'h1234, 16'h1111, 16'h7777, 16'h2345, 16'h0000, 1'b1, 1'b1, 1'b0, 2'd2, 8'd3},  // R3
    '{5'd2,  16'h0001, 16'h0002, 16'h0000, 16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 1'b0, 2'd2, 8'd3},  // R3 borrow
    '{5'd2,  16'h5000, 16'h1000, 16'h1234, 16'h4000, 16'h0000, 1'b1, 1'b1, 1'b0, 2'd2, 8'd3},  // R3
    '{5'd3,  16'hFFFF, 16'hFFFF, 16'h0000, 16'h0001, 16'hFFFE, 1'b1, 1'b1, 1'b0, 2'd2, 8'd4},  // R4
    '{5'd4,  16'hFFFF, 16'h0002, 16'h0000, 16'hFFFE, 16'hFFFF, 1'b1, 1'b1, 1'b0, 2'd2, 8'd4},  // R4 signed
    '{5'd3,  16'h0100, 16'h0100, 16'h0000, 16'h0000, 16'h0001, 1'b1, 1'b1, 1'b0, 2'd2, 8'd4},  // R4
    '{5'd5,  16'h0007, 16'h0002, 16'h0000, 16'h0003, 16'h8000, 1'b1, 1'b1, 1'b0, 2'd3, 8'd5},  // R5
    '{5'd6,  16'hFFF9, 16'h0002, 16'h0000, 16'hFFFD, 16'h8000, 1'b1, 1'b1, 1'b0, 2'd3, 8'd5},  // R5 signed
    '{5'd5,  16'h1234, 16'h0000, 16'h9999, 16'h0000, 16'h0000, 1'b1, 1'b1, 1'b0, 2'd3, 8'd6},  // R6
    '{5'd7,  16'h1234, 16'h0000, 16'h4321, 16'h0000, 16'h4321, 1'b1, 1'b0, 1'b0, 2'd3, 8'd6},  // R6 rem
    '{5'd7,  16'h0064, 16'h0007, 16'h0000, 16'h0002, 16'h0000, 1'b1, 1'b0, 1'b0, 2'd3, 8'd7},  // R7
    '{5'd8,  16'hF0F0, 16'h0FF0, 16'hAAAA, 16'h00F0, 16'hAAAA, 1'b1, 1'b0, 1'b0, 2'd1, 8'd2},  // R2 and
    '{5'd9,  16'hF000, 16'h000F, 16'h0000, 16'hF00F, 16'h0000, 1'b1, 1'b0, 1'b0, 2'd1, 8'd2},  // R2 or
    '{5'd10, 16'hFFFF, 16'h0F0F, 16'h0001, 16'hF0F0, 16'h0001, 1'b1, 1'b0, 1'b0, 2'd1, 8'd2},  // R2 xor
    '{5'd11, 16'h8001, 16'h0001, 16'h0000, 16'h0002, 16'h0001, 1'b1, 1'b1, 1'b0, 2'd2, 8'd8},  // R8
    '{5'd11, 16'h1234, 16'h0010, 16'h0000, 16'h0000, 16'h1234, 1'b1, 1'b1, 1'b0, 2'd2, 8'd8},  // R8 by 16
    '{5'd11, 16'h1234, 16'h0020, 16'h0000, 16'h0000, 16'h0000, 1'b1, 1'b1, 1'b0, 2'd2, 8'd8},  // R8 by 32
    '{5'd12, 16'h8001, 16'h0001, 16'h0000, 16'h4000, 16'h8000, 1'b1, 1'b1, 1'b0, 2'd2, 8'd9},  // R9
    '{5'd13, 16'h8001, 16'h0001, 16'h0000, 16'hC000, 16'h8000, 1'b1, 1'b1, 1'b0, 2'd2, 8'd9},  // R9
    '{5'd13, 16'h8000, 16'h0014, 16'h0000, 16'hFFFF, 16'hF800, 1'b1, 1'b1, 1'b0, 2'd2, 8'd9},  // R9 big
    '{5'd12, 16'h8000, 16'h0014, 16'h0000, 16'h0000, 16'h0800, 1'b1, 1'b1, 1'b0, 2'd2, 8'd9},  // R9 big
    '{5'd14, 16'hFFFF, 16'h0000, 16'h0001, 16'h0000, 16'h0001, 1'b1, 1'b1, 1'b0, 2'd3, 8'd10}, // R10
    '{5'd14, 16'h0001, 16'h0002, 16'h0001, 16'h0004, 16'h0000, 1'b1, 1'b1, 1'b0, 2'd3, 8'd10}, // R10
    '{5'd15, 16'h0000, 16'h0000, 16'h0001, 16'hFFFF, 16'h0001, 1'b1, 1'b1, 1'b0, 2'd3, 8'd10}, // R10
    '{5'd15, 16'h0005, 16'h0002, 16'h0001, 16'h0002, 16'h0000, 1'b1, 1'b1, 1'b0, 2'd3, 8'd10}, // R10
    '{5'd16, 16'h0000, 16'hBEEF, 16'h1111, 16'hBEEF, 16'h1111, 1'b1, 1'b0, 1'b1, 2'd2, 8'd11}, // R11
    '{5'd17, 16'h2222, 16'h3333, 16'h4444, 16'h2222, 16'h4444, 1'b0, 1'b0, 1'b0, 2'd0, 8'd12}, // R12
    '{5'd31, 16'h5555, 16'h6666, 16'h7777, 16'h5555, 16'h7777, 1'b0, 1'b0, 1'b0, 2'd0, 8'd12}  // R12
  };

  task automatic check_out(input vec_t v);
    checks++;
    if (out_valid !== 1'b1 || out_b !== v.eb || out_ex !== v.eex || out_b_we !== v.bwe ||
        out_ex_we !== v.exwe || out_ij_inc !== v.ij || out_cost !== v.cost) begin
      errors++;
      $display("FAIL R%0d op=%0d: got v=%b b=%h ex=%h bwe=%b exwe=%b ij=%b cost=%0d expected v=1 b=%h ex=%h bwe=%b exwe=%b ij=%b cost=%0d",
               v.req, v.op, out_valid, out_b, out_ex, out_b_we, out_ex_we, out_ij_inc, out_cost,
               v.eb, v.eex, v.bwe, v.exwe, v.ij, v.cost);
    end
  endtask

  task automatic check_idle(input string tag);
    checks++;
    if (out_valid !== 1'b0 || out_b_we !== 1'b0 || out_ex_we !== 1'b0 ||
        out_ij_inc !== 1'b0) begin
      errors++;
      $display("FAIL %s: got v=%b bwe=%b exwe=%b ij=%b expected all 0",
               tag, out_valid, out_b_we, out_ex_we, out_ij_inc);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (out_valid !== 1'b0 || out_b_we !== 1'b0 || out_ex_we !== 1'b0 ||
        out_ij_inc !== 1'b0 || out_cost !== 2'd0) begin
      errors++;
      $display("FAIL R1 reset: got v=%b bwe=%b exwe=%b ij=%b cost=%0d expected 0",
               out_valid, out_b_we, out_ex_we, out_ij_inc, out_cost);
    end
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 idle after reset");
    // table walked back to back
    for (int i = 0; i < NV; i++) begin
      in_valid = 1'b1;
      in_op = VECS[i].op;
      in_b  = VECS[i].b;
      in_a  = VECS[i].a;
      in_ex = VECS[i].ex;
      @(negedge clk);
      check_out(VECS[i]);
    end
    // R1 drop of valid
    in_valid = 1'b0;
    in_op = 5'd16;
    @(negedge clk);
    check_idle("R1 valid low");
    // R11 then R2: index strobe ends after one operation
    in_valid = 1'b1; in_op = 5'd16; in_a = 16'h0042; in_b = 16'h0; in_ex = 16'h0;
    @(negedge clk);
    check_out('{5'd16, 16'h0, 16'h0042, 16'h0, 16'h0042, 16'h0, 1'b1, 1'b0, 1'b1, 2'd2, 8'd11});
    in_op = 5'd0; in_a = 16'h0007;
    @(negedge clk);
    check_out('{5'd0, 16'h0, 16'h0007, 16'h0, 16'h0007, 16'h0, 1'b1, 1'b0, 1'b0, 2'd1, 8'd11});
    // R6 signed divide by zero
    in_op = 5'd6; in_b = 16'h8000; in_a = 16'h0; in_ex = 16'hFFFF;
    @(negedge clk);
    check_out('{5'd6, 16'h8000, 16'h0, 16'hFFFF, 16'h0, 16'h0, 1'b1, 1'b1, 1'b0, 2'd3, 8'd6});
    // R5 signed divide most negative by -1
    in_op = 5'd6; in_b = 16'h8000; in_a = 16'hFFFF; in_ex = 16'h0;
    @(negedge clk);
    check_out('{5'd6, 16'h8000, 16'hFFFF, 16'h0, 16'h8000, 16'h0000, 1'b1, 1'b1, 1'b0, 2'd3, 8'd5});
    // R10 add-with-carry wrap with full EX
    in_op = 5'd14; in_b = 16'hFFFF; in_a = 16'hFFFF; in_ex = 16'hFFFF;
    @(negedge clk);
    check_out('{5'd14, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFD, 16'h0001, 1'b1, 1'b1, 1'b0, 2'd3, 8'd10});
    in_valid = 1'b0;
    @(negedge clk);
    check_idle("R1 final idle");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule